// File: doc/BRIEF.md
# Multiplexed Peripheral Bus Strobe Sequencer

This block produces the control strobes for a single access on a peripheral bus where address and data share one set of wires. A one-cycle request, together with a direction bit, starts an access. The block first drives an address latch strobe, then a chip select. Inside the chip select window it drives either a read output-enable or a write strobe. Every strobe edge sits at a cycle offset taken from its own timing field. The address latch strobe is the reference for the write strobe. The chip select is the reference for the output enable.

When chip select drops, the block enters a recovery period. This period is one fixed cycle plus a programmable number of extra cycles, so the bus can turn around before the next access. While an access or its recovery is running, the block reports busy and ignores further requests. A one-cycle done pulse marks the return to the ready state. The timing fields and the direction are captured when a request is accepted. Software can therefore reprogram them while an access is running without disturbing it.

Top module: `mbs_sequencer`

## Requirements
- R1: During and straight after synchronous reset, every output (ale, cs, oe, wr, drv_en, busy, done) is low and the block is ready to accept a request.
- R2: A request sampled high at a rising edge while ready starts an access. Number its cycles from t=0, the first cycle after that edge. ale is high for t < A, where A is cfg_ale_len with 0 treated as 1.
- R3: cs is high for A+G <= t < E, where G is cfg_ale_gap, C is cfg_cs_len with 0 treated as 1, and E = A+G+C. When G is 0, cs starts in the cycle right after the last ale cycle. ale and cs are never high together.
- R4: On a write (is_write=1), wr is high for cfg_wr_delay <= t < cfg_wr_delay+cfg_wr_len, and only while t < E. On a read, wr stays low.
- R5: On a read, oe is high in chip select cycle k (k = t-A-G) when k >= cfg_oe_lead and k+cfg_oe_trail < C. If no k meets both conditions, oe stays low for the whole access. On a write, oe stays low.
- R6: drv_en is high exactly in the chip select cycles of a write access, and low at all other times.
- R7: For t from E to E+cfg_idle_extra, busy stays high and all strobes are low. busy is high from t=0 through t=E+cfg_idle_extra. In the next cycle busy is low and done is high for exactly one cycle.
- R8: A request seen while busy is ignored. A request seen in the done cycle, or in any later ready cycle, is accepted.
- R9: The timing fields and is_write are taken at the accepting edge. Changes to them during an access have no effect on that access.
- R10: The setting A=1, G=1, C=17, oe_lead=0, oe_trail=0, wr_delay=8, wr_len=8, idle_extra=2 on a write gives 17 chip select cycles, 8 write strobe cycles and 22 busy cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Access request, sampled while ready |
| is_write | input | 1 | 1 = write access, 0 = read access |
| cfg_ale_len | input | CW | Address latch strobe length (0 acts as 1) |
| cfg_ale_gap | input | CW | Cycles from end of ale to start of cs |
| cfg_cs_len | input | CW | Chip select length, sets access length (0 acts as 1) |
| cfg_oe_lead | input | CW | Cycles from cs start to oe start |
| cfg_oe_trail | input | CW | Cycles from oe end to cs end |
| cfg_wr_delay | input | CW | Cycles from ale start to wr start |
| cfg_wr_len | input | CW | Write strobe length |
| cfg_idle_extra | input | CW | Idle cycles added to the fixed one |
| ale | output | 1 | Address latch strobe |
| cs | output | 1 | Chip select |
| oe | output | 1 | Read output enable |
| wr | output | 1 | Write strobe |
| drv_en | output | 1 | Data drive enable for writes |
| busy | output | 1 | Access or recovery in progress |
| done | output | 1 | One-cycle end-of-access pulse |

## Verification
The bench builds the block with the default field width CW=6, so every timing field can reach 63. This allows a directed access at the largest chip select and idle lengths, where a write strobe window runs past the end of chip select and must be cut off. A read case places the output enable window past its own end, so oe must stay low. Fields of zero test the clamp on the latch and chip select lengths and the gap-free path from ale straight to cs. Random traffic keeps the request line and the fields changing during accesses, which exercises the hold-off and the captured configuration.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

    // Number of timing fields carried in the flat configuration vector
    localparam int unsigned NUM_FIELDS = 8;

    // Field slots, slot 0 in the least significant position
    localparam int unsigned FLD_IDLE_EXTRA = 0;
    localparam int unsigned FLD_WR_LEN     = 1;
    localparam int unsigned FLD_WR_DELAY   = 2;
    localparam int unsigned FLD_OE_TRAIL   = 3;
    localparam int unsigned FLD_OE_LEAD    = 4;
    localparam int unsigned FLD_CS_LEN     = 5;
    localparam int unsigned FLD_ALE_GAP    = 6;
    localparam int unsigned FLD_ALE_LEN    = 7;

    typedef enum logic [2:0] {
        PH_READY = 3'd0,
        PH_ALE   = 3'd1,
        PH_GAP   = 3'd2,
        PH_CS    = 3'd3,
        PH_IDLE  = 3'd4
    } phase_e;

    // Length fields that must span at least one cycle
    function automatic logic needs_floor(int unsigned fld);
        return (fld == FLD_ALE_LEN) || (fld == FLD_CS_LEN);
    endfunction

    function automatic logic phase_active(phase_e ph);
        return (ph == PH_ALE) || (ph == PH_GAP) || (ph == PH_CS);
    endfunction

endpackage

// File: rtl/mbs_cfg_capture.sv
module mbs_cfg_capture
    import mbs_pkg::*;
#(
    parameter int unsigned CW = 6
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     load,
    input  logic                     is_write,
    input  logic [NUM_FIELDS*CW-1:0] cfg_raw,
    output logic [NUM_FIELDS*CW-1:0] cfg_q,
    output logic                     wr_q
);
    localparam int unsigned FW = NUM_FIELDS * CW;

    logic [FW-1:0] cfg_fixed;

    // Length fields get a floor of one cycle; the others pass unchanged
    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_fld
        if (needs_floor(f)) begin : g_floor
            assign cfg_fixed[f*CW +: CW] =
                (cfg_raw[f*CW +: CW] == '0) ? CW'(1) : cfg_raw[f*CW +: CW];
        end else begin : g_pass
            assign cfg_fixed[f*CW +: CW] = cfg_raw[f*CW +: CW];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            wr_q  <= 1'b0;
        end else if (load) begin
            cfg_q <= cfg_fixed;
            wr_q  <= is_write;
        end
    end

endmodule

// File: rtl/mbs_phase_ctrl.sv
module mbs_phase_ctrl
    import mbs_pkg::*;
#(
    parameter int unsigned CW = 6
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic [NUM_FIELDS*CW-1:0] cfg_q,
    output phase_e                   phase,
    output logic [CW-1:0]            pcnt,
    output logic [CW+1:0]            elapsed,
    output logic                     accept,
    output logic                     done
);
    logic [CW-1:0] ale_len, ale_gap, cs_len, idle_extra;

    assign ale_len    = cfg_q[FLD_ALE_LEN*CW    +: CW];
    assign ale_gap    = cfg_q[FLD_ALE_GAP*CW    +: CW];
    assign cs_len     = cfg_q[FLD_CS_LEN*CW     +: CW];
    assign idle_extra = cfg_q[FLD_IDLE_EXTRA*CW +: CW];

    assign accept = (phase == PH_READY) && start;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_READY;
            pcnt    <= '0;
            elapsed <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (phase)
                PH_READY: begin
                    if (start) begin
                        phase   <= PH_ALE;
                        pcnt    <= '0;
                        elapsed <= '0;
                    end
                end
                PH_ALE: begin
                    elapsed <= elapsed + 1'b1;
                    if (pcnt == ale_len - 1'b1) begin
                        pcnt  <= '0;
                        phase <= (ale_gap == '0) ? PH_CS : PH_GAP;
                    end else begin
                        pcnt <= pcnt + 1'b1;
                    end
                end
                PH_GAP: begin
                    elapsed <= elapsed + 1'b1;
                    if (pcnt == ale_gap - 1'b1) begin
                        pcnt  <= '0;
                        phase <= PH_CS;
                    end else begin
                        pcnt <= pcnt + 1'b1;
                    end
                end
                PH_CS: begin
                    elapsed <= elapsed + 1'b1;
                    if (pcnt == cs_len - 1'b1) begin
                        pcnt  <= '0;
                        phase <= PH_IDLE;
                    end else begin
                        pcnt <= pcnt + 1'b1;
                    end
                end
                PH_IDLE: begin
                    if (pcnt == idle_extra) begin
                        pcnt  <= '0;
                        phase <= PH_READY;
                        done  <= 1'b1;
                    end else begin
                        pcnt <= pcnt + 1'b1;
                    end
                end
                default: begin
                    phase <= PH_READY;
                    pcnt  <= '0;
                end
            endcase
        end
    end

    // R7: done lasts one cycle and only follows the recovery period
    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r7_done_after_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(phase) == PH_IDLE) && (phase != PH_IDLE));
    // R8: a new access only ever starts from the ready state
    a_r8_start_from_ready: assert property (@(posedge clk) disable iff (rst)
        ((phase == PH_ALE) && ($past(phase) != PH_ALE)) |-> ($past(phase) == PH_READY));
    // R7: recovery is entered only from the chip select phase
    a_r7_idle_after_cs: assert property (@(posedge clk) disable iff (rst)
        ((phase == PH_IDLE) && ($past(phase) != PH_IDLE)) |-> ($past(phase) == PH_CS));

endmodule

// File: rtl/mbs_strobe_gen.sv
module mbs_strobe_gen
    import mbs_pkg::*;
#(
    parameter int unsigned CW = 6
) (
    input  logic                     clk,
    input  logic                     rst,
    input  phase_e                   phase,
    input  logic [CW-1:0]            pcnt,
    input  logic [CW+1:0]            elapsed,
    input  logic [NUM_FIELDS*CW-1:0] cfg_q,
    input  logic                     wr_q,
    output logic                     ale,
    output logic                     cs,
    output logic                     oe,
    output logic                     wr,
    output logic                     drv_en
);
    localparam int unsigned EW = CW + 2;

    logic [CW-1:0] cs_len, oe_lead, oe_trail, wr_delay, wr_len;
    logic [EW-1:0] wr_lo, wr_hi;
    logic [CW:0]   oe_sum;
    logic          in_access;

    assign cs_len   = cfg_q[FLD_CS_LEN*CW   +: CW];
    assign oe_lead  = cfg_q[FLD_OE_LEAD*CW  +: CW];
    assign oe_trail = cfg_q[FLD_OE_TRAIL*CW +: CW];
    assign wr_delay = cfg_q[FLD_WR_DELAY*CW +: CW];
    assign wr_len   = cfg_q[FLD_WR_LEN*CW   +: CW];

    // Write window measured from the first address latch cycle
    assign wr_lo     = EW'(wr_delay);
    assign wr_hi     = EW'(wr_delay) + EW'(wr_len);
    // Read window measured from the first chip select cycle
    assign oe_sum    = {1'b0, pcnt} + {1'b0, oe_trail};
    assign in_access = phase_active(phase);

    always_comb begin
        ale    = (phase == PH_ALE);
        cs     = (phase == PH_CS);
        wr     = wr_q && in_access && (elapsed >= wr_lo) && (elapsed < wr_hi);
        oe     = !wr_q && (phase == PH_CS) && (pcnt >= oe_lead)
                 && (oe_sum < {1'b0, cs_len});
        drv_en = wr_q && (phase == PH_CS);
    end

    // R3: latch strobe and chip select never overlap
    a_r3_ale_cs_excl: assert property (@(posedge clk) disable iff (rst)
        !(ale && cs));
    // R6: data drive only inside chip select
    a_r6_drv_in_cs: assert property (@(posedge clk) disable iff (rst)
        drv_en |-> cs);
    // R5: output enable only inside chip select and never with the write strobe
    a_r5_oe_in_cs: assert property (@(posedge clk) disable iff (rst)
        oe |-> (cs && !wr && !drv_en));
    // R4: write strobe never outlives chip select
    a_r4_wr_not_after_cs: assert property (@(posedge clk) disable iff (rst)
        (wr && $past(cs)) |-> cs);

endmodule

// File: rtl/mbs_sequencer.sv
module mbs_sequencer
    import mbs_pkg::*;
#(
    parameter int unsigned CW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          is_write,
    input  logic [CW-1:0] cfg_ale_len,
    input  logic [CW-1:0] cfg_ale_gap,
    input  logic [CW-1:0] cfg_cs_len,
    input  logic [CW-1:0] cfg_oe_lead,
    input  logic [CW-1:0] cfg_oe_trail,
    input  logic [CW-1:0] cfg_wr_delay,
    input  logic [CW-1:0] cfg_wr_len,
    input  logic [CW-1:0] cfg_idle_extra,
    output logic          ale,
    output logic          cs,
    output logic          oe,
    output logic          wr,
    output logic          drv_en,
    output logic          busy,
    output logic          done
);
    localparam int unsigned FW = NUM_FIELDS * CW;
    localparam int unsigned EW = CW + 2;

    logic [FW-1:0] cfg_raw, cfg_q;
    logic          wr_q, accept;
    phase_e        phase;
    logic [CW-1:0] pcnt;
    logic [EW-1:0] elapsed;

    assign cfg_raw = {cfg_ale_len, cfg_ale_gap, cfg_cs_len, cfg_oe_lead,
                      cfg_oe_trail, cfg_wr_delay, cfg_wr_len, cfg_idle_extra};

    mbs_cfg_capture #(.CW(CW)) cap_i (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .is_write (is_write),
        .cfg_raw  (cfg_raw),
        .cfg_q    (cfg_q),
        .wr_q     (wr_q)
    );

    mbs_phase_ctrl #(.CW(CW)) ctrl_i (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .cfg_q   (cfg_q),
        .phase   (phase),
        .pcnt    (pcnt),
        .elapsed (elapsed),
        .accept  (accept),
        .done    (done)
    );

    mbs_strobe_gen #(.CW(CW)) strb_i (
        .clk     (clk),
        .rst     (rst),
        .phase   (phase),
        .pcnt    (pcnt),
        .elapsed (elapsed),
        .cfg_q   (cfg_q),
        .wr_q    (wr_q),
        .ale     (ale),
        .cs      (cs),
        .oe      (oe),
        .wr      (wr),
        .drv_en  (drv_en)
    );

    assign busy = (phase != PH_READY);

    // R9: captured configuration is frozen across a running access
    a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(cfg_q) && $stable(wr_q)));
    // R7: busy and done are never high together
    a_r7_busy_done_excl: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));
    // R2: an access always opens with the latch strobe
    a_r2_open_with_ale: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ale);

endmodule

// File: tb/mbs_sequencer_tb.sv
module mbs_sequencer_tb_top;
    localparam int CW = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic is_write = 1'b0;
    logic [CW-1:0] f_ale_len = '0, f_ale_gap = '0, f_cs_len = '0, f_oe_lead = '0;
    logic [CW-1:0] f_oe_trail = '0, f_wr_delay = '0, f_wr_len = '0, f_idle = '0;
    logic ale, cs, oe, wr, drv_en, busy, done;

    int vectors = 0;
    int fails = 0;
    bit finished = 1'b0;

    // reference model state
    int  mt = -1;
    bit  mdone = 1'b0;
    bit  mwr = 1'b0;
    int  mA, mG, mC, mL, mT, mW, mWL, mI;

    always #10 clk = ~clk;

    mbs_sequencer #(.CW(CW)) dut_i (
        .clk(clk), .rst(rst), .start(start), .is_write(is_write),
        .cfg_ale_len(f_ale_len), .cfg_ale_gap(f_ale_gap), .cfg_cs_len(f_cs_len),
        .cfg_oe_lead(f_oe_lead), .cfg_oe_trail(f_oe_trail),
        .cfg_wr_delay(f_wr_delay), .cfg_wr_len(f_wr_len), .cfg_idle_extra(f_idle),
        .ale(ale), .cs(cs), .oe(oe), .wr(wr), .drv_en(drv_en),
        .busy(busy), .done(done)
    );

    task automatic chk(input string req, input string sig, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s at %0t: actual=%b expected=%b (t=%0d)", req, sig, $time, act, exp, mt);
        end
    endtask

    // model advance across the rising edge that has just passed
    task automatic advance();
        if (rst) begin
            mt = -1; mdone = 1'b0;
        end else if (mt < 0) begin
            mdone = 1'b0;
            if (start) begin
                mt  = 0;
                mwr = is_write;
                mA  = (f_ale_len == 0) ? 1 : int'(f_ale_len);
                mG  = int'(f_ale_gap);
                mC  = (f_cs_len == 0) ? 1 : int'(f_cs_len);
                mL  = int'(f_oe_lead);
                mT  = int'(f_oe_trail);
                mW  = int'(f_wr_delay);
                mWL = int'(f_wr_len);
                mI  = int'(f_idle);
            end
        end else if (mt == mA + mG + mC + mI) begin
            mt = -1; mdone = 1'b1;
        end else begin
            mt++;
        end
    endtask

    function automatic bit exp_cs(int t);
        return (t >= mA + mG) && (t < mA + mG + mC);
    endfunction

    function automatic bit exp_oe(int t);
        int k;
        k = t - mA - mG;
        return !mwr && exp_cs(t) && (k >= mL) && (k + mT < mC);
    endfunction

    function automatic bit exp_wr(int t);
        return mwr && (t >= mW) && (t < mW + mWL) && (t < mA + mG + mC);
    endfunction

    task automatic check_all();
        if (rst) begin
            chk("R1", "ale", ale, 1'b0);  chk("R1", "cs", cs, 1'b0);
            chk("R1", "oe", oe, 1'b0);    chk("R1", "wr", wr, 1'b0);
            chk("R1", "drv_en", drv_en, 1'b0);
            chk("R1", "busy", busy, 1'b0); chk("R1", "done", done, 1'b0);
        end else if (mt < 0) begin
            chk("R8", "busy", busy, 1'b0); chk("R7", "done", done, mdone);
            chk("R2", "ale", ale, 1'b0);  chk("R3", "cs", cs, 1'b0);
            chk("R4", "wr", wr, 1'b0);    chk("R5", "oe", oe, 1'b0);
            chk("R6", "drv_en", drv_en, 1'b0);
        end else begin
            chk("R7", "busy", busy, 1'b1); chk("R7", "done", done, 1'b0);
            chk("R2", "ale", ale, mt < mA);
            chk("R3", "cs", cs, exp_cs(mt));
            chk("R4", "wr", wr, exp_wr(mt));
            chk("R5", "oe", oe, exp_oe(mt));
            chk("R6", "drv_en", drv_en, mwr && exp_cs(mt));
        end
    endtask

    task automatic step();
        @(negedge clk);
        advance();
        check_all();
    endtask

    task automatic set_cfg(input int a, g, c, l, t, w, wl, i);
        f_ale_len = CW'(a); f_ale_gap = CW'(g); f_cs_len = CW'(c); f_oe_lead = CW'(l);
        f_oe_trail = CW'(t); f_wr_delay = CW'(w); f_wr_len = CW'(wl); f_idle = CW'(i);
    endtask

    task automatic run_directed(input bit wdir);
        is_write = wdir; start = 1'b1;
        step();
        start = 1'b0;
        while (busy === 1'b1) step();
        step();
    endtask

    initial begin : main
        int n_cs, n_wr, n_busy;
        void'($urandom(32'd1250));
        start = 1'b1;                         // R1: request during reset is ignored
        repeat (3) step();
        rst = 1'b0; start = 1'b0;
        step();

        // R10: reference setting on a write
        set_cfg(1, 1, 17, 0, 0, 8, 8, 2);
        is_write = 1'b1; start = 1'b1;
        step();
        start = 1'b0;
        n_cs = 0; n_wr = 0; n_busy = 0;
        while (busy === 1'b1) begin
            n_busy++; n_cs += int'(cs); n_wr += int'(wr);
            set_cfg(3, 3, 3, 3, 3, 3, 3, 3);   // R9: mid-access change
            is_write = 1'b0;
            step();
        end
        chk("R10", "cs_cycles", n_cs == 17, 1'b1);
        chk("R10", "wr_cycles", n_wr == 8, 1'b1);
        chk("R10", "busy_cycles", n_busy == 22, 1'b1);
        step();

        // R3/R2: zero lengths clamp to one, no gap
        set_cfg(0, 0, 0, 0, 0, 0, 1, 0);
        run_directed(1'b1);
        // R4: long write window cut off by end of chip select, widest fields
        set_cfg(2, 0, 63, 0, 0, 10, 63, 63);
        run_directed(1'b1);
        // R5: read with an empty output enable window
        set_cfg(1, 2, 6, 4, 3, 0, 0, 0);
        run_directed(1'b0);
        // R5: read with lead and trail
        set_cfg(2, 1, 10, 2, 3, 0, 5, 1);
        run_directed(1'b0);

        // R8/R9: random traffic with requests held during busy and back-to-back
        for (int i = 0; i < 4000; i++) begin
            start    = ($urandom % 100) < 40;
            is_write = $urandom % 2;
            set_cfg($urandom % 4, $urandom % 4, $urandom % 21, $urandom % 7,
                    $urandom % 7, $urandom % 26, $urandom % 13, $urandom % 5);
            step();
        end
        start = 1'b0;
        repeat (120) step();

        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule